// File: doc/BRIEF.md
# GCI 2B+D Channel Slot Interface

This block places one 8-bit B channel into the ISDN GCI frame and takes one out. Four line signals are used: a frame clock, a data clock, serial data out and serial data in. A fifth input, the receive bit clock of the plain PCM port, selects the mode. When that input stays low across enough frame-clock edges, the block switches into GCI operation. The block sees its first rising edge as the command to leave GCI operation.

Inside a frame, the two B channels follow each other. The first channel takes data-clock cycles 0 to 15, counted from the frame-clock rising edge. The second channel takes cycles 16 to 31. A select input chooses which of the two channels the block serves, for both directions. Each bit is held for two data-clock cycles, so data moves at half the data-clock rate.

All line inputs are oversampled in one system clock domain. Edges of the data clock and of the frame clock are found after a synchronizer. The transmit byte is supplied in parallel and is captured at the start of each frame. The byte received in the slot is delivered in parallel together with a one-clock valid strobe.

Top module: `gci_slot_if`

## Requirements
- R1: After reset, `dout_oe_o`, `dout_o`, `gci_mode_o` and `rx_valid_o` are 0 and `rx_data_o` is all zeros.
- R2: `gci_mode_o` rises at the MODE_FRAMES-th frame-clock rising edge (default 2) seen while `bclkr_i` is low with no rising edge of `bclkr_i` in between. The frame that this edge opens is already served. Fewer edges leave the mode off.
- R3: A rising edge on `bclkr_i` clears `gci_mode_o` within 4 system clocks. The edge count restarts from zero.
- R4: A frame-clock rising edge, which coincides with a data-clock rising edge, makes that data-clock cycle cycle 0. Channel B1 (select 0) covers cycles 0..15 and channel B2 (select 1) covers cycles 16..31.
- R5: `sel_i` and `tx_data_i` are captured at the frame-clock rising edge. Changing them later in the frame has no effect on that frame.
- R6: In the served slot, `dout_o` carries the captured byte MSB first. Bit k (k = 0 for the MSB) is held through slot cycles 2k and 2k+1, and changes only after data-clock rising edges.
- R7: `dout_oe_o` is 1 only during the selected slot while the mode is on. Otherwise `dout_oe_o` and `dout_o` are 0.
- R8: `din_i` is sampled at the data-clock falling edge that ends the second cycle of each bit in the served slot, MSB first. After the eighth sample, `rx_data_o` holds the byte and `rx_valid_o` pulses for one system clock.
- R9: Cycles after 31 carry no slot. Without a new frame-clock edge, the cycle count saturates and no slot recurs.
- R10: While the mode is off, or when no slot is served, `din_i` is ignored and `rx_valid_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversampling the line |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fsc_i | input | 1 | Frame clock |
| dcl_i | input | 1 | Data clock, twice the bit rate |
| bclkr_i | input | 1 | Receive bit clock, used for mode selection |
| sel_i | input | SEL_W | Channel choice: 0 = B1, 1 = B2 |
| din_i | input | 1 | Serial data in |
| tx_data_i | input | CH_BITS | Byte to send in the served slot |
| dout_o | output | 1 | Serial data out, 0 while not driven |
| dout_oe_o | output | 1 | Output enable for the external tri-state driver |
| rx_data_o | output | CH_BITS | Last byte received |
| rx_valid_o | output | 1 | One-clock strobe when rx_data_o updates |
| gci_mode_o | output | 1 | GCI operation active |

## Verification
The assertions rely on three assumptions about the inputs. Every frame-clock rising edge arrives together with a data-clock rising edge. Each data-clock half period spans several system clocks, so a rising edge and a falling edge are never detected in back-to-back clocks. The serial input stays steady across each sampling edge. The bench satisfies these assumptions by driving the data clock, the frame clock and the serial input from the same system-clock falling edge. Each data-clock half lasts six system clocks, and the serial input is changed only at data-clock rising edges.

// File: rtl/gci_pkg.sv
package gci_pkg;
  // bit positions in the synchronized line vector
  localparam int unsigned SIG_DCL   = 0;
  localparam int unsigned SIG_FSC   = 1;
  localparam int unsigned SIG_BCLKR = 2;
  localparam int unsigned SIG_DIN   = 3;
  localparam int unsigned SIG_NUM   = 4;

  typedef struct packed {
    logic act;    // selected slot is live
    logic half2;  // second data-clock cycle of the current bit
  } gci_slot_t;
endpackage

// File: rtl/gci_sync_edge.sv
module gci_sync_edge #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chain_q <= '0;
        prev_q  <= 1'b0;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], d_i[i]};
        prev_q  <= chain_q[STAGES-1];
      end
    end

    assign lvl_o[i]  = chain_q[STAGES-1];
    assign rise_o[i] = chain_q[STAGES-1] & ~prev_q;
    assign fall_o[i] = ~chain_q[STAGES-1] & prev_q;
  end
endmodule

// File: rtl/gci_mode_detect.sv
module gci_mode_detect #(
  parameter int unsigned MODE_FRAMES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclkr_lvl_i,
  input  logic bclkr_rise_i,
  input  logic frame_rise_i,
  output logic mode_o
);
  localparam int unsigned CW = $clog2(MODE_FRAMES + 1);
  localparam logic [CW-1:0] CNT_SAT = CW'(MODE_FRAMES);
  localparam logic [CW-1:0] CNT_ARM = CW'(MODE_FRAMES - 1);

  logic [CW-1:0] cnt_q;
  logic          mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mode_q <= 1'b0;
    end else if (bclkr_rise_i) begin
      cnt_q  <= '0;
      mode_q <= 1'b0;
    end else if (bclkr_lvl_i) begin
      cnt_q  <= '0;
    end else if (frame_rise_i) begin
      if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
      if (cnt_q >= CNT_ARM) mode_q <= 1'b1;
    end
  end

  assign mode_o = mode_q;

  p_exit_on_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bclkr_rise_i |=> !mode_q);

  p_entry_on_frame_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mode_q) |-> ($past(frame_rise_i) && !$past(bclkr_lvl_i)));
endmodule

// File: rtl/gci_slot_ctrl.sv
module gci_slot_ctrl
  import gci_pkg::*;
#(
  parameter int unsigned CH_BITS     = 8,
  parameter int unsigned CYC_PER_BIT = 2,
  parameter int unsigned NUM_CH      = 2,
  parameter int unsigned SEL_W       = 1,
  parameter int unsigned IW          = $clog2(CH_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_rise_i,
  input  logic             clk_rise_i,
  input  logic             mode_i,
  input  logic [SEL_W-1:0] sel_i,
  output gci_slot_t        slot_o,
  output logic [IW-1:0]    bit_idx_o
);
  localparam int unsigned SLOT_CYC  = CH_BITS * CYC_PER_BIT;
  localparam int unsigned FRAME_CYC = SLOT_CYC * NUM_CH;
  localparam int unsigned CNT_W     = $clog2(FRAME_CYC) + 1;

  logic [CNT_W-1:0] cyc_q, base, offs;
  logic [SEL_W-1:0] sel_q;
  logic             in_win;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= '1;  // no slot until the first frame edge
      sel_q <= '0;
    end else if (frame_rise_i) begin
      cyc_q <= '0;
      sel_q <= sel_i;
    end else if (clk_rise_i && (cyc_q != '1)) begin
      cyc_q <= cyc_q + 1'b1;
    end
  end

  always_comb begin
    base      = CNT_W'(sel_q) * CNT_W'(SLOT_CYC);
    in_win    = (cyc_q >= base) && (cyc_q < base + CNT_W'(SLOT_CYC));
    offs      = cyc_q - base;
    bit_idx_o = IW'(offs / CNT_W'(CYC_PER_BIT));
    slot_o.half2 = (offs % CNT_W'(CYC_PER_BIT)) == CNT_W'(CYC_PER_BIT - 1);
    slot_o.act   = mode_i && in_win;
  end

  p_frame_restart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_rise_i |=> (cyc_q == '0));

  p_count_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_rise_i && !clk_rise_i) |=> $stable(cyc_q));
endmodule

// File: rtl/gci_shifter.sv
module gci_shifter
  import gci_pkg::*;
#(
  parameter int unsigned CH_BITS = 8,
  parameter int unsigned IW      = $clog2(CH_BITS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_rise_i,
  input  logic               clk_rise_i,
  input  logic               clk_fall_i,
  input  logic               din_i,
  input  logic [CH_BITS-1:0] tx_data_i,
  input  gci_slot_t          slot_i,
  input  logic [IW-1:0]      bit_idx_i,
  output logic               dout_o,
  output logic               dout_oe_o,
  output logic [CH_BITS-1:0] rx_data_o,
  output logic               rx_valid_o
);
  localparam logic [IW-1:0] LAST = IW'(CH_BITS - 1);

  logic [CH_BITS-1:0] tx_q, rx_sh_q;
  logic [IW-1:0]      msb_idx;
  logic               sample;

  assign msb_idx   = LAST - bit_idx_i;
  assign dout_oe_o = slot_i.act;
  assign dout_o    = slot_i.act ? tx_q[msb_idx] : 1'b0;
  assign sample    = slot_i.act && slot_i.half2 && clk_fall_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q       <= '0;
      rx_sh_q    <= '0;
      rx_data_o  <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      if (frame_rise_i) tx_q <= tx_data_i;
      if (sample) begin
        rx_sh_q <= {rx_sh_q[CH_BITS-2:0], din_i};
        if (bit_idx_i == LAST) begin
          rx_data_o  <= {rx_sh_q[CH_BITS-2:0], din_i};
          rx_valid_o <= 1'b1;
        end
      end
    end
  end

  p_dout_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dout_oe_o && $past(dout_oe_o) && !$past(clk_rise_i) && !$past(frame_rise_i))
      |-> $stable(dout_o));

  p_valid_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
endmodule

// File: rtl/gci_slot_if.sv
module gci_slot_if
  import gci_pkg::*;
#(
  parameter int unsigned CH_BITS     = 8,
  parameter int unsigned CYC_PER_BIT = 2,
  parameter int unsigned NUM_CH      = 2,
  parameter int unsigned MODE_FRAMES = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SEL_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fsc_i,
  input  logic               dcl_i,
  input  logic               bclkr_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               din_i,
  input  logic [CH_BITS-1:0] tx_data_i,
  output logic               dout_o,
  output logic               dout_oe_o,
  output logic [CH_BITS-1:0] rx_data_o,
  output logic               rx_valid_o,
  output logic               gci_mode_o
);
  localparam int unsigned IW = $clog2(CH_BITS);

  logic [SIG_NUM-1:0] line_d, lvl, rise, fall;
  logic               mode;
  gci_slot_t          slot;
  logic [IW-1:0]      bit_idx;
  logic               unused_edges;

  assign line_d[SIG_DCL]   = dcl_i;
  assign line_d[SIG_FSC]   = fsc_i;
  assign line_d[SIG_BCLKR] = bclkr_i;
  assign line_d[SIG_DIN]   = din_i;

  assign unused_edges = ^{lvl[SIG_DCL], lvl[SIG_FSC], fall[SIG_FSC],
                          fall[SIG_BCLKR], rise[SIG_DIN], fall[SIG_DIN]};

  gci_sync_edge #(.W(SIG_NUM), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (line_d),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  gci_mode_detect #(.MODE_FRAMES(MODE_FRAMES)) u_mode (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bclkr_lvl_i  (lvl[SIG_BCLKR]),
    .bclkr_rise_i (rise[SIG_BCLKR]),
    .frame_rise_i (rise[SIG_FSC]),
    .mode_o       (mode)
  );

  gci_slot_ctrl #(
    .CH_BITS(CH_BITS), .CYC_PER_BIT(CYC_PER_BIT), .NUM_CH(NUM_CH),
    .SEL_W(SEL_W), .IW(IW)
  ) u_slot (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_rise_i (rise[SIG_FSC]),
    .clk_rise_i   (rise[SIG_DCL]),
    .mode_i       (mode),
    .sel_i        (sel_i),
    .slot_o       (slot),
    .bit_idx_o    (bit_idx)
  );

  gci_shifter #(.CH_BITS(CH_BITS), .IW(IW)) u_shift (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_rise_i (rise[SIG_FSC]),
    .clk_rise_i   (rise[SIG_DCL]),
    .clk_fall_i   (fall[SIG_DCL]),
    .din_i        (lvl[SIG_DIN]),
    .tx_data_i    (tx_data_i),
    .slot_i       (slot),
    .bit_idx_i    (bit_idx),
    .dout_o       (dout_o),
    .dout_oe_o    (dout_oe_o),
    .rx_data_o    (rx_data_o),
    .rx_valid_o   (rx_valid_o)
  );

  assign gci_mode_o = mode;

  p_oe_needs_mode_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_oe_o |-> gci_mode_o);
endmodule

// File: tb/tb_gci_slot_if.sv
module tb_gci_slot_if;
  localparam int H         = 6;   // system clocks per data-clock half
  localparam int FRAME_LEN = 36;  // data-clock cycles per frame

  logic       clk = 1'b0;
  logic       rst_n;
  logic       fsc_i, dcl_i, bclkr_i, din_i;
  logic [0:0] sel_i;
  logic [7:0] tx_data_i;
  logic       dout_o, dout_oe_o, rx_valid_o, gci_mode_o;
  logic [7:0] rx_data_o;

  int checks = 0;
  int fails  = 0;
  int vcnt   = 0;
  logic [7:0] rx_cap = '0;

  always #5 clk = ~clk;

  gci_slot_if dut (
    .clk_i(clk), .rst_ni(rst_n), .fsc_i(fsc_i), .dcl_i(dcl_i), .bclkr_i(bclkr_i),
    .sel_i(sel_i), .din_i(din_i), .tx_data_i(tx_data_i), .dout_o(dout_o),
    .dout_oe_o(dout_oe_o), .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o),
    .gci_mode_o(gci_mode_o)
  );

  always @(posedge clk) begin
    if (rst_n && rx_valid_o) begin
      vcnt   <= vcnt + 1;
      rx_cap <= rx_data_o;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic dcl_cycle(input bit fs, input bit d, input bit exp_oe, input bit exp_bit);
    @(negedge clk);
    dcl_i = 1'b1; fsc_i = fs; din_i = d;
    repeat (H - 1) @(negedge clk);
    chk(dout_oe_o == exp_oe, "R7", "dout_oe", int'(dout_oe_o), int'(exp_oe));
    if (exp_oe) chk(dout_o == exp_bit, "R6", "dout bit", int'(dout_o), int'(exp_bit));
    else        chk(dout_o == 1'b0, "R7", "idle dout", int'(dout_o), 0);
    @(negedge clk);
    dcl_i = 1'b0;
    repeat (H - 1) @(negedge clk);
  endtask

  task automatic run_frame(input bit has_fs, input bit sel, input logic [7:0] tx,
                           input logic [7:0] rxb, input bit exp_mode, input bit flip);
    int v0;
    int base;
    v0 = vcnt;
    base = sel ? 16 : 0;
    sel_i = sel; tx_data_i = tx;
    for (int c = 0; c < FRAME_LEN; c++) begin
      bit in_slot, d, e_oe, e_bit;
      int idx;
      in_slot = (c >= base) && (c < base + 16);
      idx     = in_slot ? (c - base) / 2 : 0;
      d       = in_slot ? rxb[7 - idx] : (c[0] ^ c[2]);
      e_oe    = exp_mode && has_fs && in_slot;
      e_bit   = e_oe ? tx[7 - idx] : 1'b0;
      if (flip && c == 3) begin  // R5: late changes ignored
        sel_i = ~sel; tx_data_i = ~tx;
      end
      dcl_cycle(has_fs && c == 0, d, e_oe, e_bit);
      if (c == 0) chk(gci_mode_o == exp_mode, "R2", "mode at frame start",
                      int'(gci_mode_o), int'(exp_mode));
    end
    if (exp_mode && has_fs) begin
      chk(vcnt - v0 == 1, "R8", "valid pulses", vcnt - v0, 1);
      chk(rx_cap == rxb, "R8", "rx byte", int'(rx_cap), int'(rxb));
    end else begin
      chk(vcnt - v0 == 0, "R10", "valid pulses idle", vcnt - v0, 0);
    end
    sel_i = sel; tx_data_i = tx;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog run did not finish");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; fsc_i = 0; dcl_i = 0; bclkr_i = 1'b1; din_i = 0;
    sel_i = '0; tx_data_i = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(dout_oe_o == 0, "R1", "oe", int'(dout_oe_o), 0);
    chk(dout_o == 0, "R1", "dout", int'(dout_o), 0);
    chk(gci_mode_o == 0, "R1", "mode", int'(gci_mode_o), 0);
    chk(rx_valid_o == 0, "R1", "valid", int'(rx_valid_o), 0);
    chk(rx_data_o == 0, "R1", "rx_data", int'(rx_data_o), 0);

    // receive clock high: no mode (R2, R10)
    run_frame(1, 0, 8'hA5, 8'h3C, 0, 0);
    bclkr_i = 1'b0;
    run_frame(1, 0, 8'hA5, 8'h3C, 0, 0);   // R2: one edge is not enough
    run_frame(1, 0, 8'hA5, 8'h3C, 1, 0);   // R2: second edge enters, frame served

    // R4 R6 R8: sweep both slots with computed bytes
    for (int s = 0; s < 2; s++) begin
      for (int k = 0; k < 6; k++) begin
        logic [7:0] tx, rb;
        tx = 8'(k * 53 + 17 + s * 7);
        rb = 8'(k * 29 + 200 - s * 11);
        run_frame(1, s[0], tx, rb, 1, 0);
      end
    end
    // boundary bytes
    for (int s = 0; s < 2; s++) begin
      run_frame(1, s[0], 8'h00, 8'hFF, 1, 0);
      run_frame(1, s[0], 8'hFF, 8'h00, 1, 0);
      run_frame(1, s[0], 8'h80, 8'h01, 1, 0);
      run_frame(1, s[0], 8'h01, 8'h80, 1, 0);
    end
    // R5: select and data changed mid-frame
    run_frame(1, 0, 8'h96, 8'h5A, 1, 1);
    run_frame(1, 1, 8'h69, 8'hC3, 1, 1);

    // R9: frame clock missing, count saturates
    run_frame(0, 0, 8'hF0, 8'h0F, 1, 0);
    run_frame(1, 1, 8'h3E, 8'hE3, 1, 0);

    // R3: leave on receive clock rising edge
    @(negedge clk); bclkr_i = 1'b1;
    repeat (5) @(negedge clk);
    chk(gci_mode_o == 0, "R3", "mode after rise", int'(gci_mode_o), 0);
    run_frame(1, 0, 8'h55, 8'hAA, 0, 0);
    bclkr_i = 1'b0;
    run_frame(1, 1, 8'h55, 8'hAA, 0, 0);   // R3: count restarted
    run_frame(1, 1, 8'h5C, 8'hA7, 1, 0);

    summary();
    $finish;
  end
endmodule